// File: doc/BRIEF.md
# GPIO Output Unit with Change Events

This unit drives sixteen general-purpose output pins from two stored words, a data word and an output-enable word. Both are written and read one byte at a time over a simple single-byte register bus. A pin is driven high only when its data bit and its enable bit are both set, so software can preload data while the pins stay low.

Each write that lands on either word starts an evaluation. The gated pin levels are compared with the levels recorded at the previous evaluation. Every pin whose level moved raises its own bit of a 16-bit change strobe for exactly one clock. The new level of each such pin is presented alongside the strobe. The recorded level is then updated. The words are three bytes wide, but only the lowest sixteen bits reach the pins.

Top module: `gpio_out_events`

## Requirements
- R1: While reset is high and in the first cycle after it, the data word, enable word, pins, change strobe and change level are all zero.
- R2: Data bytes sit at addresses 0x78, 0x79 and 0x7A, and enable bytes sit at 0x7C, 0x7D and 0x7E. The byte at base+k holds word bits 8k+7 down to 8k.
- R3: A byte write replaces only its own 8-bit lane of the addressed word. The other lanes and the other word keep their values.
- R4: Pin i equals data bit i AND enable bit i for i in 0..15. The pins show a write from the cycle after the clock edge that accepts it.
- R5: For a write accepted at edge E, the change strobe is high during the cycle that follows edge E+1, and for that one cycle only. It is set exactly on the bits whose gated level differs from the level recorded at the previous evaluation. Under each set strobe bit, the change level carries the new pin level.
- R6: A write that leaves every gated level unchanged raises no strobe bit. Examples are rewriting the same value, or changing data under a cleared enable.
- R7: Bits 23..16 of both words are stored and read back, but they never affect the pins or the strobes.
- R8: Reads are combinational on the address and return the raw stored data or enable byte, not the gated level. Unmapped addresses read as 0x00.
- R9: Writes to addresses outside the six mapped bytes change no stored state and raise no strobe.
- R10: Writes on consecutive cycles are each evaluated in turn. Each is compared against the level recorded by the evaluation just before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the byte bus |
| addr | input | 8 | Byte address for reads and writes |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte for the current address |
| pin_out | output | 16 | Gated pin levels |
| chg_strobe | output | 16 | Per-pin one-cycle change strobe |
| chg_level | output | 16 | New pin levels, valid under set strobe bits |

## Verification
The assertions take for granted that `wr_en`, `addr` and `wr_data` are settled at every rising edge. They also assume a write cycle is any cycle with `wr_en` high; no handshake is expected. The bench changes inputs only just after a falling edge and holds them through the next rising edge. It mixes directed sequences with a pseudo-random run. That run includes unmapped addresses and back-to-back writes, so strobes from one evaluation sit next to a fresh pending evaluation.

// File: rtl/gpo_pkg.sv
package gpo_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 8;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_OE   = 2'd2
    } sel_e;

    typedef struct packed {
        sel_e              sel;
        logic [ADDR_W-1:0] lane;
    } dec_t;

    // Map a byte address onto one of the two words and a lane within it.
    function automatic dec_t decode(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] base_d,
                                    input logic [ADDR_W-1:0] base_o,
                                    input int                lanes);
        dec_t r;
        r.sel  = SEL_NONE;
        r.lane = '0;
        if (int'(a) >= int'(base_d) && int'(a) < int'(base_d) + lanes) begin
            r.sel  = SEL_DATA;
            r.lane = a - base_d;
        end else if (int'(a) >= int'(base_o) && int'(a) < int'(base_o) + lanes) begin
            r.sel  = SEL_OE;
            r.lane = a - base_o;
        end
        return r;
    endfunction

endpackage

// File: rtl/gpo_regbank.sv
module gpo_regbank
    import gpo_pkg::*;
#(
    parameter int                NLANES    = 3,
    parameter logic [ADDR_W-1:0] DATA_BASE = 8'h78,
    parameter logic [ADDR_W-1:0] OE_BASE   = 8'h7C,
    localparam int               WORD_W    = NLANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic [WORD_W-1:0] data_word,
    output logic [WORD_W-1:0] oe_word,
    output logic              wr_hit
);

    dec_t              dec;
    logic [WORD_W-1:0] data_q;
    logic [WORD_W-1:0] oe_q;
    logic [WORD_W-1:0] lane_mask;

    always_comb dec = decode(addr, DATA_BASE, OE_BASE, NLANES);

    assign wr_hit    = wr_en && (dec.sel != SEL_NONE);
    assign data_word = data_q;
    assign oe_word   = oe_q;

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                data_q[g*BYTE_W +: BYTE_W] <= '0;
                oe_q[g*BYTE_W +: BYTE_W]   <= '0;
            end else if (wr_en && dec.lane == ADDR_W'(g)) begin
                if (dec.sel == SEL_DATA) data_q[g*BYTE_W +: BYTE_W] <= wr_data;
                if (dec.sel == SEL_OE)   oe_q[g*BYTE_W +: BYTE_W]   <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data   = '0;
        lane_mask = '0;
        for (int i = 0; i < NLANES; i++) begin
            if (dec.lane == ADDR_W'(i)) begin
                lane_mask[i*BYTE_W +: BYTE_W] = '1;
                if (dec.sel == SEL_DATA) rd_data = data_q[i*BYTE_W +: BYTE_W];
                if (dec.sel == SEL_OE)   rd_data = oe_q[i*BYTE_W +: BYTE_W];
            end
        end
    end

    AST_OE_HOLD_ON_DATA_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.sel == SEL_DATA) |=> $stable(oe_q)); // R3
    AST_DATA_LANE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.sel == SEL_DATA) |=> (((data_q ^ $past(data_q)) & ~$past(lane_mask)) == '0)); // R3
    AST_HOLD_WITHOUT_HIT: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> ($stable(data_q) && $stable(oe_q))); // R9

endmodule

// File: rtl/gpo_change.sv
module gpo_change #(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_hit,
    input  logic [NPINS-1:0] data_lo,
    input  logic [NPINS-1:0] oe_lo,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] strobe,
    output logic [NPINS-1:0] evt_level
);

    logic             pend;
    logic [NPINS-1:0] level;
    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] strobe_q;
    logic [NPINS-1:0] evt_q;

    assign level     = data_lo & oe_lo;
    assign pin_out   = level;
    assign strobe    = strobe_q;
    assign evt_level = evt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= 1'b0;
            prev_q   <= '0;
            strobe_q <= '0;
            evt_q    <= '0;
        end else begin
            pend     <= wr_hit;
            strobe_q <= pend ? (prev_q ^ level) : '0;
            if (pend) begin
                prev_q <= level;
                evt_q  <= level;
            end
        end
    end

    AST_EVT_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        (|strobe_q) |-> $past(pend)); // R5
    AST_PREV_IN_SYNC: assert property (@(posedge clk) disable iff (rst)
        !pend |-> (prev_q == level)); // R5

endmodule

// File: rtl/gpio_out_events.sv
module gpio_out_events
    import gpo_pkg::*;
#(
    parameter int                NPINS     = 16,
    parameter int                NLANES    = 3,
    parameter logic [ADDR_W-1:0] DATA_BASE = 8'h78,
    parameter logic [ADDR_W-1:0] OE_BASE   = 8'h7C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  chg_strobe,
    output logic [NPINS-1:0]  chg_level
);

    localparam int WORD_W = NLANES * BYTE_W;

    logic [WORD_W-1:0] data_word;
    logic [WORD_W-1:0] oe_word;
    logic              wr_hit;

    gpo_regbank #(
        .NLANES   (NLANES),
        .DATA_BASE(DATA_BASE),
        .OE_BASE  (OE_BASE)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .data_word(data_word),
        .oe_word  (oe_word),
        .wr_hit   (wr_hit)
    );

    // Only the low NPINS bits reach the pins; the rest are storage only (R7).
    if (NPINS < WORD_W) begin : g_upper
        logic unused_upper;
        assign unused_upper = ^{data_word[WORD_W-1:NPINS], oe_word[WORD_W-1:NPINS]};
    end

    gpo_change #(
        .NPINS(NPINS)
    ) u_chg (
        .clk      (clk),
        .rst      (rst),
        .wr_hit   (wr_hit),
        .data_lo  (data_word[NPINS-1:0]),
        .oe_lo    (oe_word[NPINS-1:0]),
        .pin_out  (pin_out),
        .strobe   (chg_strobe),
        .evt_level(chg_level)
    );

    AST_PINS_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(pin_out)); // R4

endmodule

// File: tb/sim_gpio_out_events.sv
module sim_gpio_out_events;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  rd_data;
    logic [15:0] pin_out;
    logic [15:0] chg_strobe;
    logic [15:0] chg_level;

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural reference state
    logic [7:0]  m_data [3];
    logic [7:0]  m_oe   [3];
    logic [15:0] m_prev = '0;
    logic [15:0] m_strobe = '0;
    logic [15:0] m_level = '0;
    bit          m_pend = 0;

    always #(CLK_P/2) clk = ~clk;

    gpio_out_events u0 (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .pin_out   (pin_out),
        .chg_strobe(chg_strobe),
        .chg_level (chg_level)
    );

    function automatic logic [15:0] m_pins();
        return {m_data[1], m_data[0]} & {m_oe[1], m_oe[0]};
    endfunction

    function automatic logic [7:0] m_read(input logic [7:0] a);
        if (a >= 8'h78 && a <= 8'h7A) return m_data[a - 8'h78];
        if (a >= 8'h7C && a <= 8'h7E) return m_oe[a - 8'h7C];
        return 8'h00;
    endfunction

    function automatic bit m_mapped(input logic [7:0] a);
        return (a >= 8'h78 && a <= 8'h7A) || (a >= 8'h7C && a <= 8'h7E);
    endfunction

    task automatic model_edge(input logic r, input logic we, input logic [7:0] a, input logic [7:0] d);
        if (r) begin
            for (int i = 0; i < 3; i++) begin m_data[i] = 8'h00; m_oe[i] = 8'h00; end
            m_prev = '0; m_strobe = '0; m_level = '0; m_pend = 0;
        end else begin
            m_strobe = m_pend ? (m_prev ^ m_pins()) : 16'h0;
            if (m_pend) begin m_prev = m_pins(); m_level = m_pins(); end
            m_pend = we && m_mapped(a);
            if (we && a >= 8'h78 && a <= 8'h7A) m_data[a - 8'h78] = d;
            if (we && a >= 8'h7C && a <= 8'h7E) m_oe[a - 8'h7C] = d;
        end
    endtask

    task automatic cmp16(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        cmp16(tag, "pin_out", pin_out, m_pins());
        cmp16(tag, "chg_strobe", chg_strobe, m_strobe);
        cmp16(tag, "chg_level", chg_level & m_strobe, m_level & m_strobe);
        cmp16(tag, "rd_data", {8'h00, rd_data}, {8'h00, m_read(addr)});
    endtask

    task automatic step(input logic we, input logic [7:0] a, input logic [7:0] d, input string tag);
        wr_en = we; addr = a; wr_data = d;
        @(posedge clk);
        model_edge(rst, we, a, d);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [15:0] lf;
        logic [7:0]  pick;
        // R1: reset state
        rst = 1'b1;
        repeat (3) step(1'b1, 8'h78, 8'hFF, "R1");
        rst = 1'b0;
        step(1'b0, 8'h78, 8'h00, "R1");
        step(1'b0, 8'h7C, 8'h00, "R1");

        // R6: data under cleared enable moves no pin
        step(1'b1, 8'h78, 8'hFF, "R6");
        step(1'b0, 8'h78, 8'h00, "R6");
        step(1'b0, 8'h78, 8'h00, "R6");
        // R4/R5: enable low nibble
        step(1'b1, 8'h7C, 8'h0F, "R4");
        step(1'b0, 8'h7C, 8'h00, "R5");
        step(1'b0, 8'h7C, 8'h00, "R5");
        // R10: back-to-back writes on lane 1
        step(1'b1, 8'h79, 8'hA5, "R10");
        step(1'b1, 8'h7D, 8'hFF, "R10");
        step(1'b1, 8'h7D, 8'h0F, "R10");
        step(1'b0, 8'h79, 8'h00, "R10");
        step(1'b0, 8'h7D, 8'h00, "R10");
        // R2/R3: lane placement and isolation
        step(1'b1, 8'h78, 8'h3C, "R3");
        step(1'b0, 8'h79, 8'h00, "R3");
        step(1'b0, 8'h7C, 8'h00, "R2");
        // R7: top lane stored but never on pins
        step(1'b1, 8'h7A, 8'hFF, "R7");
        step(1'b1, 8'h7E, 8'hFF, "R7");
        step(1'b0, 8'h7A, 8'h00, "R7");
        step(1'b0, 8'h7E, 8'h00, "R7");
        // R9: unmapped writes ignored
        step(1'b1, 8'h7B, 8'hFF, "R9");
        step(1'b1, 8'h7F, 8'hFF, "R9");
        step(1'b1, 8'h00, 8'hFF, "R9");
        step(1'b0, 8'h7B, 8'h00, "R9");
        step(1'b0, 8'h78, 8'h00, "R9");
        // R6: rewrite same value
        step(1'b1, 8'h78, 8'h3C, "R6");
        step(1'b0, 8'h78, 8'h00, "R6");
        step(1'b0, 8'h78, 8'h00, "R6");
        // R8: raw readback of every mapped byte and a gap
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 8'h78 + 8'(i), 8'h00, "R8");
            step(1'b0, 8'h7C + 8'(i), 8'h00, "R8");
        end
        step(1'b0, 8'hC0, 8'h00, "R8");

        // R4/R5/R10: pseudo-random mix
        lf = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (lf[2:0])
                3'd0: pick = 8'h78;
                3'd1: pick = 8'h79;
                3'd2: pick = 8'h7A;
                3'd3: pick = 8'h7C;
                3'd4: pick = 8'h7D;
                3'd5: pick = 8'h7E;
                3'd6: pick = 8'h7B;
                default: pick = 8'h40;
            endcase
            step(lf[3] | lf[4], pick, lf[15:8], "R5");
        end
        step(1'b0, 8'h78, 8'h00, "R5");
        step(1'b0, 8'h78, 8'h00, "R5");

        // R1: reset again clears everything
        rst = 1'b1;
        step(1'b0, 8'h79, 8'h00, "R1");
        rst = 1'b0;
        step(1'b0, 8'h79, 8'h00, "R1");
        report();
    end

endmodule